// File: doc/BRIEF.md
# Ratio-Checked Dual-Clock Update FIFO

This block carries small update words from a fast write clock domain into a slower read clock domain. The words pass through an eight-entry pointer FIFO. The two pointers cross between the domains in Gray code, each through two synchronizing flops. The two clocks are expected to keep a fixed relationship: five write-clock rising edges for every two read-clock rising edges. After reset, the read side holds its pointer and reports not ready. It stays that way until it has evidence that the write clock is actually toggling.

An edge-count monitor measures the write clock against the read clock. The read side marks out windows of two read edges with a toggle. The write side counts its own edges between successive toggle changes. Each count is sent back through a second toggle handshake, using a pair of alternating holding registers.

Every count after the settling windows is compared with five. Any other value raises a sticky slip flag. This catches the case where a clock switch lets a sixth write edge into one window. A single-cycle realign pulse on the read side then flushes both pointers through a four-phase request and acknowledge exchange, clears the flag and restarts the startup hold.

Top module: `cdc_rate_fifo`

## Requirements
- R1: Words are delivered on `rd_data` in the order they were accepted on the write side; `rd_data` is meaningful while `rd_valid` is 1, and a read-side pop is `rd_en` high on a read-clock rising edge with `rd_valid` high.
- R2: `wr_full` is 1 when DEPTH (8) words are unread; a write offered while `wr_full` is 1 is dropped and the stored words are unchanged.
- R3: `rd_valid` is 0 when no unread word is present, and `rd_en` asserted while `rd_valid` is 0 does not move the read pointer.
- R4: After reset, `ready` and `rd_valid` stay 0 until SETTLE (2) window reports have arrived from a running write clock; while the write clock is stopped, `ready` stays 0 and words already written are not presented.
- R5: `edges_seen` shows the number of write-clock rising edges counted in the most recent window of WIN_R (2) read-clock rising edges; with the nominal ratio it reads RATIO_W (5).
- R6: Once `ready` has been reached, any window count other than RATIO_W sets `slip` (1 = ratio violated), which then holds until reset or realign, including after the ratio recovers.
- R7: A one-cycle `realign` pulse drops `ready`, clears `slip`, discards every stored word on both sides, and re-enters the startup hold of R4.
- R8: While reset is asserted and in the first read cycle after its release, `ready`, `rd_valid`, `slip` and `wr_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock (fast side) |
| wr_en | input | 1 | Offer `wr_data` to the FIFO |
| wr_data | input | DW | Update word to store |
| wr_full | output | 1 | FIFO holds DEPTH unread words |
| rclk | input | 1 | Read clock (slow side) |
| rd_en | input | 1 | Pop the word shown on `rd_data` |
| rd_data | output | DW | Oldest unread word |
| rd_valid | output | 1 | A word is available and the read side is ready |
| realign | input | 1 | Read-domain pulse that flushes and restarts the FIFO |
| ready | output | 1 | Startup hold finished, reads permitted |
| slip | output | 1 | Sticky flag: a window had a count other than RATIO_W |
| edges_seen | output | CW | Write edges counted in the latest window |

## Verification
The bound checker watches four things on every clock edge. The write pointer stays still on a write into a full FIFO. The read pointer stays still when a pop meets an empty FIFO or arrives during the startup hold. A realign exchange always leaves the read pointer at zero with `slip` and `ready` low. A raised slip flag persists unless a realign starts.

The relation between the clock edges and the measured count can only be shown by the bench's scenarios. These are an extra write edge and a lost write edge, each inserted into an otherwise exact 5:2 clock pair. The same holds for the startup hold with the write clock stopped, and for the discarding of words across a realign.

// File: rtl/cdc_rate_fifo.sv
module cdc_rate_fifo #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int RATIO_W = 5,
  parameter int WIN_R   = 2,
  parameter int CW      = 4,
  parameter int SETTLE  = 2
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          realign,
  output logic          ready,
  output logic          slip,
  output logic [CW-1:0] edges_seen
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int WPW = (WIN_R > 1) ? $clog2(WIN_R) : 1;
  localparam int SW  = $clog2(SETTLE + 1);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // write domain
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx, rg_s1, rg_s2;
  logic          wreq_s1, wreq_s2, wflush;
  logic          win_s1, win_s2, win_prev, wpar, wdone;
  logic [CW-1:0] ecnt, ecap, slot0, slot1;
  logic          wpush;

  // read domain
  logic [PW-1:0] rbin, rgray, rbin_nx, wg_s1, wg_s2;
  logic          req, ack_s1, ack_s2, busy;
  logic [WPW-1:0] rph;
  logic          rwin, d_s1, d_s2, d_prev, rpar, report;
  logic [SW-1:0] skip;
  logic [CW-1:0] rep_cnt;
  logic          rpop, empty;

  assign wflush  = wreq_s2;
  assign wr_full = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign wpush   = wr_en && !wr_full && !wflush;
  assign wbin_nx = wflush ? '0 : (wpush ? wbin + 1'b1 : wbin);
  assign ecap    = (ecnt == '1) ? ecnt : ecnt + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      wreq_s1 <= 1'b0; wreq_s2 <= 1'b0;
      win_s1 <= 1'b0; win_s2 <= 1'b0; win_prev <= 1'b0;
      wpar <= 1'b0; wdone <= 1'b0; ecnt <= '0;
      slot0 <= '0; slot1 <= '0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= to_gray(wbin_nx);
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      wreq_s1 <= req;
      wreq_s2 <= wreq_s1;
      win_s1  <= rwin;
      win_s2  <= win_s1;
      win_prev <= win_s2;
      if (win_s2 != win_prev) begin
        if (wpar) slot1 <= ecap;
        else      slot0 <= ecap;
        wpar  <= ~wpar;
        wdone <= ~wdone;
        ecnt  <= '0;
      end else if (ecnt != '1) begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign busy     = req | ack_s2;
  assign report   = d_s2 != d_prev;
  assign rep_cnt  = rpar ? slot1 : slot0;
  assign empty    = (rgray == wg_s2);
  assign ready    = (skip == SW'(SETTLE)) && !busy;
  assign rd_valid = ready && !empty;
  assign rpop     = rd_en && rd_valid;
  assign rbin_nx  = busy ? '0 : (rpop ? rbin + 1'b1 : rbin);
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      req <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
      rph <= '0; rwin <= 1'b0;
      d_s1 <= 1'b0; d_s2 <= 1'b0; d_prev <= 1'b0; rpar <= 1'b0;
      skip <= '0; slip <= 1'b0; edges_seen <= '0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= to_gray(rbin_nx);
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      ack_s1 <= wreq_s2;
      ack_s2 <= ack_s1;
      if (realign)     req <= 1'b1;
      else if (ack_s2) req <= 1'b0;
      if (rph == WPW'(WIN_R - 1)) begin
        rph  <= '0;
        rwin <= ~rwin;
      end else begin
        rph <= rph + 1'b1;
      end
      d_s1   <= wdone;
      d_s2   <= d_s1;
      d_prev <= d_s2;
      if (report) begin
        rpar       <= ~rpar;
        edges_seen <= rep_cnt;
      end
      if (busy) begin
        skip <= '0;
        slip <= 1'b0;
      end else if (report) begin
        if (skip != SW'(SETTLE))            skip <= skip + 1'b1;
        else if (rep_cnt != CW'(RATIO_W))   slip <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdc_rate_fifo_chk.sv
module cdc_rate_fifo_chk #(
  parameter int PW = 4
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          wr_en,
  input logic          wr_full,
  input logic          wflush,
  input logic [PW-1:0] wbin,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          ready,
  input logic          busy,
  input logic          realign,
  input logic          slip,
  input logic [PW-1:0] rbin
);
  a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_full && wr_en && !wflush) |=> $stable(wbin));

  a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && !rd_valid && !busy) |=> $stable(rbin));

  a_r4_hold_freezes_read: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ready && !busy) |=> $stable(rbin));

  a_r6_slip_sticky: assert property (@(posedge rclk) disable iff (!rst_n)
    (slip && !realign && !busy) |=> slip);

  a_r7_realign_clears: assert property (@(posedge rclk) disable iff (!rst_n)
    busy |=> (rbin == '0) && !slip && !ready);
endmodule

bind cdc_rate_fifo cdc_rate_fifo_chk #(.PW(PW)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk),
  .wr_en(wr_en), .wr_full(wr_full), .wflush(wflush), .wbin(wbin),
  .rd_en(rd_en), .rd_valid(rd_valid), .ready(ready), .busy(busy),
  .realign(realign), .slip(slip), .rbin(rbin)
);

// File: tb/tb_cdc_rate_fifo.sv
`timescale 1ns/1ps
module tb_cdc_rate_fifo;
  localparam int DW = 8;

  logic          rst_n = 1'b0;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, realign = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_valid, ready, slip;
  logic [3:0]    edges_seen;

  real wh = 2.5;
  bit  wrun = 1'b1;
  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;

  cdc_rate_fifo dut (
    .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .realign(realign), .ready(ready), .slip(slip), .edges_seen(edges_seen)
  );

  always begin
    #(wh);
    if (wrun) wclk = ~wclk;
  end

  initial begin
    #1;
    forever #6.25 rclk = ~rclk;
  end

  localparam logic [DW-1:0] VEC [12] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80,
                                         8'h3C, 8'hC3, 8'h7E, 8'h81, 8'h12, 8'hED};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rwait(input int n);
    repeat (n) @(posedge rclk);
    #1;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(posedge wclk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge wclk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pop_expect(input logic [DW-1:0] exp, input string req);
    int t = 0;
    @(posedge rclk); #1;
    while (!rd_valid && t < 40) begin @(posedge rclk); #1; t++; end
    chk(rd_valid, req, "rd_valid before pop", int'(rd_valid), 1);
    chk(rd_data == exp, req, "rd_data", int'(rd_data), int'(exp));
    rd_en = 1'b1;
    @(posedge rclk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    int t = 0;
    while (!ready && t < lim) begin @(posedge rclk); #1; t++; end
  endtask

  task automatic extra_edge();
    @(posedge wclk); #1; wh = 1.25;
    #6; wh = 2.5;
  endtask

  task automatic lost_edge();
    @(posedge wclk); #1; wh = 7.5;
    #2; wh = 2.5;
  endtask

  task automatic do_realign();
    @(posedge rclk); #1; realign = 1'b1;
    @(posedge rclk); #1; realign = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R8: reset state
    #30;
    chk(!ready && !rd_valid && !slip && !wr_full, "R8", "outputs in reset",
        {ready, rd_valid, slip, wr_full}, 0);
    #73; rst_n = 1'b1;
    rwait(1);
    chk(!ready && !rd_valid && !slip && !wr_full, "R8", "outputs after release",
        {ready, rd_valid, slip, wr_full}, 0);

    // R4: startup hold, words written early not shown until ready
    push(8'h99);
    rwait(1);
    chk(!ready && !rd_valid, "R4", "hold after early write", {ready, rd_valid}, 0);
    wait_ready(100);
    chk(ready, "R4", "ready after settle", int'(ready), 1);
    pop_expect(8'h99, "R4");

    // R5: steady-ratio window count
    rwait(12);
    chk(edges_seen == 4'd5, "R5", "edges per window", int'(edges_seen), 5);
    chk(!slip, "R6", "no slip at nominal ratio", int'(slip), 0);

    // R1: vector table in bursts of four
    for (int i = 0; i < 12; i += 4) begin
      for (int j = 0; j < 4; j++) push(VEC[i + j]);
      for (int j = 0; j < 4; j++) pop_expect(VEC[i + j], "R1");
    end
    rwait(6);
    chk(!rd_valid, "R3", "empty after table", int'(rd_valid), 0);

    // R3: pop on empty has no effect
    rd_en = 1'b1; rwait(3); rd_en = 1'b0;
    push(8'h4D);
    pop_expect(8'h4D, "R3");

    // R2: fill, overflow dropped
    for (int k = 0; k < 8; k++) push(8'h40 + 8'(k));
    chk(wr_full, "R2", "full at depth", int'(wr_full), 1);
    push(8'hEE);
    chk(wr_full, "R2", "still full after dropped write", int'(wr_full), 1);
    for (int k = 0; k < 8; k++) pop_expect(8'h40 + 8'(k), "R2");
    rwait(6);
    chk(!rd_valid, "R2", "overflow word not stored", int'(rd_valid), 0);
    #20;
    chk(!wr_full, "R2", "full cleared after drain", int'(wr_full), 0);

    // R6: extra write edge sets sticky slip
    extra_edge();
    rwait(12);
    chk(slip, "R6", "slip after sixth edge", int'(slip), 1);
    rwait(20);
    chk(slip, "R6", "slip stays after recovery", int'(slip), 1);
    chk(edges_seen == 4'd5, "R5", "count back to nominal", int'(edges_seen), 5);

    // R7: realign with stored words
    push(8'h11); push(8'h22); push(8'h33);
    rwait(4);
    do_realign();
    rwait(1);
    chk(!ready, "R7", "ready dropped", int'(ready), 0);
    chk(!slip, "R7", "slip cleared", int'(slip), 0);
    wait_ready(100);
    chk(ready, "R7", "ready after realign", int'(ready), 1);
    rwait(4);
    chk(!rd_valid, "R7", "stored words discarded", int'(rd_valid), 0);
    push(8'h5C);
    pop_expect(8'h5C, "R7");

    // R6: lost write edge also flags
    rwait(8);
    chk(!slip, "R6", "clean before lost edge", int'(slip), 0);
    lost_edge();
    rwait(12);
    chk(slip, "R6", "slip after lost edge", int'(slip), 1);

    // R4: write clock stopped through reset
    @(negedge wclk); wrun = 1'b0;
    rst_n = 1'b0; #20; rst_n = 1'b1;
    rwait(40);
    chk(!ready && !rd_valid, "R4", "no ready with stopped write clock",
        {ready, rd_valid}, 0);
    wrun = 1'b1;
    wait_ready(100);
    chk(ready, "R4", "ready once write clock runs", int'(ready), 1);
    chk(!slip, "R8", "slip clear after reset", int'(slip), 0);

    rwait(4);
    summary();
  end
endmodule